// File: doc/BRIEF.md
# Shared-Address Interrupt Request Controller

This block gathers eight maskable interrupt sources into one level-sensitive request line for the processor. Each source is a single-cycle event pulse from a peripheral. A byte-wide register port exposes one address with two meanings. A write to that address loads the enable mask. A read from the same address returns the pending bits, not the mask. Because of this, the hardware never shows the mask to software, and software must keep its own copy in memory.

A source latches a pending bit only while it is enabled. The request output stays high for as long as any pending bit is set. Software acknowledges a source by writing a zero to its enable bit. This clears the latch. Software then writes the bit back to 1 to re-arm the source.

Top module: `irq_mask_unit`

## Requirements
- R1: A synchronous reset clears the enable mask and every pending bit, so `irq` is 0 and a status read returns 0x00 afterwards.
- R2: A write (`sel`=1, `wr_en`=1) to address `REG_ADDR` (default 0xE) loads `wdata` into the 8-bit enable mask at the clock edge. A 1 in a bit enables that source.
- R3: A read (`sel`=1, `wr_en`=0) at `REG_ADDR` returns the pending bits on `rdata` in the same cycle. A 1 means that source has a request waiting. The enable mask is never returned.
- R4: An event pulse on `src_evt[i]` sets pending bit i at the next edge only if enable bit i is 1. An event on a disabled source leaves no trace.
- R5: Writing 0 to an enable bit clears the matching pending bit at that same edge. Pending bits whose enable stays 1 are kept.
- R6: `irq` is 1 exactly while at least one pending bit is 1. It stays high with no further events until software clears every pending cause.
- R7: An event on a source whose bit is already pending is absorbed. The bit stays 1 and no other bit changes.
- R8: When a mask write and an event fall in the same cycle, the event is qualified by the mask held before the write, and a bit disabled by that write ends cleared. An event arriving together with the write that enables its source is therefore lost.
- R9: Bit positions are fixed as follows. Bit 7 is break key, bit 6 keyboard, bit 5 serial receive, bit 4 serial transmit-ready, bit 3 serial transmit-done, bit 2 timer 4, bit 1 timer 2, and bit 0 timer 1. Event input i maps to status bit i.
- R10: Accesses at any other address have no effect on state, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access strobe |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | NSRC (8) | Enable mask write data |
| rdata | output | NSRC (8) | Pending status read data |
| src_evt | input | NSRC (8) | Single-cycle source event pulses |
| irq | output | 1 | Level interrupt request to the processor |

## Verification
A mask write and a source event can land in the same cycle, and that collision is the case that decides correctness. The stimulus table places writes that both widen and narrow the mask in the same cycle as events on the affected bits. Each result is then read back through the status port on the following cycle. The result is judged against the rule that the old mask qualifies the event and that a disable always wins. An enable write paired with an event must leave the bit clear. A disable write paired with an event on a pending bit must also leave that bit clear.

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter int NSRC = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'hE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   rdata,
  input  logic [NSRC-1:0]   src_evt,
  output logic              irq
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pend_q;

  wire hit    = sel && (addr == REG_ADDR);
  wire wr_hit = hit && wr_en;
  wire rd_hit = hit && !wr_en;

  wire [NSRC-1:0] en_nx   = wr_hit ? wdata : en_q;
  wire [NSRC-1:0] pend_nx = (pend_q | (src_evt & en_q)) & en_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_nx;
      pend_q <= pend_nx;
    end
  end

  assign irq   = |pend_q;
  assign rdata = rd_hit ? pend_q : '0;

endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk #(
  parameter int NSRC = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'hE
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic [NSRC-1:0]   rdata,
  input logic [NSRC-1:0]   src_evt,
  input logic              irq,
  input logic [NSRC-1:0]   en,
  input logic [NSRC-1:0]   pend
);

  wire at_reg = sel && (addr == REG_ADDR);

  assert_mask_loaded_R2: assert property (@(posedge clk) disable iff (rst)
    (at_reg && wr_en) |=> (en == $past(wdata)));

  assert_status_view_R3: assert property (@(posedge clk) disable iff (rst)
    (at_reg && !wr_en) |-> (rdata == pend));

  assert_set_needs_enabled_event_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~($past(src_evt) & $past(en))) == '0));

  assert_no_pending_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    (pend & ~en) == '0);

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
    irq == (pend != '0));

  assert_irq_held_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && !(at_reg && wr_en)) |=> irq);

  assert_other_addr_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (sel && !at_reg) |-> (rdata == '0));

endmodule

bind irq_mask_unit irq_mask_unit_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) chk_i (
  .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .src_evt(src_evt), .irq(irq), .en(en_q), .pend(pend_q)
);

// File: tb/irq_mask_unit_tb_top.sv
`timescale 1ns/100ps
module irq_mask_unit_tb_top;

  localparam logic [3:0] A = 4'hE;
  localparam int NV = 13;

  // vector: {wr, addr, wdata, evt, expected pending, requirement number}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 4'h0, 8'h00, 8'hFF, 8'h00, 8'd4},   // R4 disabled events ignored
    {1'b1, A,    8'h81, 8'h00, 8'h00, 8'd3},   // R3 mask 0x81 not visible on read
    {1'b0, 4'h0, 8'h00, 8'hFF, 8'h81, 8'd4},   // R4 only enabled bits latch (R2 mask)
    {1'b0, 4'h0, 8'h00, 8'h01, 8'h81, 8'd7},   // R7 absorbed
    {1'b1, A,    8'h80, 8'h00, 8'h80, 8'd5},   // R5 disable timer 1 clears it
    {1'b1, 4'h3, 8'h00, 8'h00, 8'h80, 8'd10},  // R10 other address write ignored
    {1'b1, A,    8'hFF, 8'h7F, 8'h80, 8'd8},   // R8 enable write + event: lost
    {1'b0, 4'h0, 8'h00, 8'h24, 8'hA4, 8'd9},   // R9 serial receive + timer 4
    {1'b1, A,    8'h00, 8'h5B, 8'h00, 8'd8},   // R8 disable wins over event
    {1'b1, A,    8'h40, 8'h00, 8'h00, 8'd2},   // R2 keyboard only
    {1'b0, 4'h0, 8'h00, 8'h40, 8'h40, 8'd9},   // R9 keyboard at bit 6
    {1'b0, 4'h0, 8'h00, 8'h00, 8'h40, 8'd6},   // R6 held with no events
    {1'b1, A,    8'h00, 8'h00, 8'h00, 8'd6}    // R6 cleared by software
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] src_evt = '0;
  logic [7:0] rdata;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_mask_unit dut_i (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_evt(src_evt), .irq(irq)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cycle(input logic w, input logic [3:0] a, input logic [7:0] d, input logic [7:0] e);
    @(negedge clk);
    sel = w; wr_en = w; addr = a; wdata = d; src_evt = e;
    @(posedge clk);
    #1;
    sel = 1'b0; wr_en = 1'b0; src_evt = '0;
  endtask

  task automatic read_at(input logic [3:0] a);
    sel = 1'b1; wr_en = 1'b0; addr = a;
    #0.5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    read_at(A);
    check8("R1", rdata, 8'h00);
    check1("R1", irq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      string tag;
      v = VEC[i];
      cycle(v[36], v[35:32], v[31:24], v[23:16]);
      read_at(A);
      tag = $sformatf("R%0d vec%0d", v[7:0], i);
      check8(tag, rdata, v[15:8]);
      check1(tag, irq, |v[15:8]);
    end

    cycle(1'b1, A, 8'hFF, 8'h00);
    cycle(1'b0, 4'h0, 8'h00, 8'h80);
    read_at(4'h2);
    check8("R10 read other address", rdata, 8'h00);
    read_at(A);
    check8("R9 break key at bit 7", rdata, 8'h80);

    cycle(1'b0, 4'h0, 8'h00, 8'hFF);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    read_at(A);
    check8("R1 reset clears pending", rdata, 8'h00);
    check1("R1 reset drops irq", irq, 1'b0);
    cycle(1'b0, 4'h0, 8'h00, 8'hFF);
    read_at(A);
    check8("R1 reset clears mask", rdata, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule